// File: doc/BRIEF.md
# PCI configuration address translator

This block sits between a host register port and a configuration-space fabric. The host first loads a 32-bit configuration address word into an index register. It then reads or writes a data window. Each data-window access is turned into one flat bus/device/function/register address. That address goes out on a downstream request port together with the write data, the byte length and the direction. Read data from the downstream response is returned to the host.

The index word can use one of three layouts, and bits 31 and 0 of the word select which one applies:
- **Passthrough:** the word is used almost unchanged.
- **Type-1-like:** the low three bits of the word are replaced by the window offset.
- **One-hot select:** a one-hot device-select field occupies bits 31:11. The device number is the position of its lowest set bit.

Host requests use valid/ready:
- The block raises `host_req_ready` only while idle.
- After a data-window access is accepted, ready stays low until the downstream response has come back, so at most one downstream request is outstanding.
- A downstream request, once valid, holds all its fields until `dn_req_ready` is seen.
- Responses to the host are single-cycle `host_rsp_valid` pulses with no back-pressure. The host must take each one.
- The downstream response is also a single-cycle pulse, and it must come at least one cycle after the request handshake.

Top module: `cfg_addr_xlate`

## Requirements
- R1: When index bit 31 is 1, the downstream address equals the index word with data-window offset bits 1:0 ORed into bits 1:0.
- R2: When index bit 31 is 0 and bit 0 is 1, the downstream address is index bits 31:3 followed by offset bits 2:0.
- R3: When index bits 31 and 0 are both 0, the device number is the position (0 to 20) of the lowest 1 in index bits 31:11. It is placed in the address starting at bit 11, with address bits above it zero.
- R4: In the one-hot layout, address bits 10:8 equal index bits 10:8 (the function), and address bits 7:3 equal index bits 7:3. Address bits 2:0 equal offset bits 2:0. Index bits 2:1 are dropped.
- R5: In the one-hot layout with index bits 31:11 all zero, address bits 31:11 are all ones.
- R6: The downstream request carries the host's byte length (1, 2 or 4) and the host's write data and direction, all unchanged.
- R7: Reset clears the index register to zero. An index read returns the last value written, and the response pulse comes in the cycle after acceptance. An index write stores all 32 bits whatever the length.
- R8: From acceptance of a data-window access until the downstream response, `host_req_ready` is low. The downstream request stays valid, with stable fields, until `dn_req_ready` is high.
- R9: A data-window read returns `dn_rsp_rdata` with `host_rsp_valid` in the cycle after `dn_rsp_valid`. Writes of either kind respond with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Block can accept a host request |
| host_req_win | input | 1 | 0 = index register, 1 = data window |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_offset | input | 12 | Byte offset inside the 4 KB region |
| host_req_len | input | 3 | Access length in bytes (1, 2 or 4) |
| host_req_wdata | input | 32 | Write data, little-endian |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_rdata | output | 32 | Read data (zero for writes) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_req_addr | output | 32 | Flat configuration address |
| dn_req_write | output | 1 | Downstream direction |
| dn_req_len | output | 3 | Downstream byte length |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream response pulse |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
The bench probes which layout each index word selects:
- A word with both bit 31 and bit 0 set must take the passthrough path. A design that tested bit 0 first would clear the low bits.
- The one-hot tests set several select bits at once, including bit 30 alone. A finder that picked the highest bit, or counted from bit 0 of the word, would give the wrong device number.
- An empty select field must fill bits 31:11 with ones rather than leave them zero.
- Dropped index bits 2:1 must not leak into the register field.

Downstream ready and response are delayed by a varying number of cycles. A design that reopened host ready early, or let the request fields move while stalled, would be caught by the per-cycle comparison.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;
  localparam int unsigned CFG_W     = 32;
  localparam int unsigned DEV_LSB   = 11;
  localparam int unsigned FUNC_LSB  = 8;
  localparam int unsigned REG_LSB   = 3;
  localparam int unsigned SEL_W     = CFG_W - DEV_LSB;
  localparam int unsigned PASS_BIT  = CFG_W - 1;
  localparam int unsigned T1_BIT    = 0;

  typedef enum logic [1:0] {
    FMT_PASS   = 2'd0,
    FMT_TYPE1  = 2'd1,
    FMT_ONEHOT = 2'd2
  } cfg_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } xl_state_e;
endpackage

// File: rtl/cfg_lowbit_finder.sv
module cfg_lowbit_finder #(
  parameter int unsigned WIDTH = 21,
  localparam int unsigned IDX_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [IDX_W-1:0] pos,
  output logic             none
);
  logic [WIDTH:0]   zero_below;
  logic [WIDTH-1:0] hit;

  assign zero_below[0] = 1'b1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    assign zero_below[g+1] = zero_below[g] & ~vec[g];
    assign hit[g]          = vec[g] & zero_below[g];
  end

  always_comb begin
    pos = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (hit[i]) pos = pos | IDX_W'(i);
    end
  end

  assign none = zero_below[WIDTH];
endmodule

// File: rtl/cfg_xlate_core.sv
module cfg_xlate_core
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned OFS_W = 12
) (
  input  logic [CFG_W-1:0] index_word,
  input  logic [OFS_W-1:0] offset,
  output cfg_fmt_e         fmt,
  output logic [CFG_W-1:0] flat_addr
);
  localparam int unsigned POS_W = $clog2(SEL_W + 1);

  logic [POS_W-1:0] dev_pos;
  logic             dev_none;
  logic [CFG_W-1:0] dev_word;
  logic [CFG_W-1:0] pass_addr;
  logic [CFG_W-1:0] t1_addr;
  logic [CFG_W-1:0] oh_addr;

  cfg_lowbit_finder #(.WIDTH(SEL_W)) u_finder (
    .vec  (index_word[CFG_W-1:DEV_LSB]),
    .pos  (dev_pos),
    .none (dev_none)
  );

  always_comb begin
    if (index_word[PASS_BIT])     fmt = FMT_PASS;
    else if (index_word[T1_BIT])  fmt = FMT_TYPE1;
    else                          fmt = FMT_ONEHOT;
  end

  assign pass_addr = index_word | {{(CFG_W-2){1'b0}}, offset[1:0]};
  assign t1_addr   = {index_word[CFG_W-1:3], offset[2:0]};
  assign dev_word  = dev_none ? {CFG_W{1'b1}} : CFG_W'(dev_pos);
  assign oh_addr   = (dev_word << DEV_LSB)
                   | {{(CFG_W-DEV_LSB){1'b0}}, index_word[DEV_LSB-1:FUNC_LSB], {FUNC_LSB{1'b0}}}
                   | {{(CFG_W-FUNC_LSB){1'b0}}, index_word[FUNC_LSB-1:REG_LSB], offset[2:0]};

  always_comb begin
    case (fmt)
      FMT_PASS:  flat_addr = pass_addr;
      FMT_TYPE1: flat_addr = t1_addr;
      default:   flat_addr = oh_addr;
    endcase
  end

  // R3: the chosen device bit is set in the index and nothing below it is
  always_comb begin
    if (!$isunknown(index_word) && fmt == FMT_ONEHOT && !dev_none) begin
      a_r3_lowest_set: assert (index_word[DEV_LSB + int'(dev_pos)] &&
        ((index_word[CFG_W-1:DEV_LSB] & ((SEL_W'(1) << dev_pos) - SEL_W'(1))) == '0));
    end
  end

  // R5: empty select field yields all-ones upper address bits
  always_comb begin
    if (!$isunknown(index_word) && fmt == FMT_ONEHOT &&
        index_word[CFG_W-1:DEV_LSB] == '0) begin
      a_r5_empty_ones: assert (&flat_addr[CFG_W-1:DEV_LSB]);
    end
  end
endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int unsigned OFS_W = 12,
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req_valid,
  output logic             host_req_ready,
  input  logic             host_req_win,
  input  logic             host_req_write,
  input  logic [OFS_W-1:0] host_req_offset,
  input  logic [LEN_W-1:0] host_req_len,
  input  logic [CFG_W-1:0] host_req_wdata,
  output logic             host_rsp_valid,
  output logic [CFG_W-1:0] host_rsp_rdata,
  output logic             dn_req_valid,
  input  logic             dn_req_ready,
  output logic [CFG_W-1:0] dn_req_addr,
  output logic             dn_req_write,
  output logic [LEN_W-1:0] dn_req_len,
  output logic [CFG_W-1:0] dn_req_wdata,
  input  logic             dn_rsp_valid,
  input  logic [CFG_W-1:0] dn_rsp_rdata
);
  xl_state_e        state;
  logic [CFG_W-1:0] index_q;
  logic [CFG_W-1:0] xl_addr;
  cfg_fmt_e         xl_fmt;
  logic             accept;

  cfg_xlate_core #(.OFS_W(OFS_W)) u_core (
    .index_word (index_q),
    .offset     (host_req_offset),
    .fmt        (xl_fmt),
    .flat_addr  (xl_addr)
  );

  assign host_req_ready = (state == ST_IDLE);
  assign accept         = host_req_valid && host_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      index_q        <= '0;
      host_rsp_valid <= 1'b0;
      host_rsp_rdata <= '0;
      dn_req_valid   <= 1'b0;
      dn_req_addr    <= '0;
      dn_req_write   <= 1'b0;
      dn_req_len     <= '0;
      dn_req_wdata   <= '0;
    end else begin
      host_rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (!host_req_win) begin
              if (host_req_write) index_q <= host_req_wdata;
              host_rsp_valid <= 1'b1;
              host_rsp_rdata <= host_req_write ? '0 : index_q;
            end else begin
              dn_req_valid <= 1'b1;
              dn_req_addr  <= xl_addr;
              dn_req_write <= host_req_write;
              dn_req_len   <= host_req_len;
              dn_req_wdata <= host_req_wdata;
              state        <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (dn_req_ready) begin
            dn_req_valid <= 1'b0;
            state        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (dn_rsp_valid) begin
            host_rsp_valid <= 1'b1;
            host_rsp_rdata <= dn_req_write ? '0 : dn_rsp_rdata;
            state          <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: stalled request holds its fields
  a_r8_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_addr) && $stable(dn_req_wdata));

  // R8: no new host access while a downstream request is pending
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid |-> !host_req_ready);

  // R6: length and direction copied from the accepted host access
  a_r6_len_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_req_valid) |-> dn_req_len == $past(host_req_len) && dn_req_write == $past(host_req_write));

  // R9: every host response has a cause one cycle earlier
  a_r9_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> $past(dn_rsp_valid) || $past(host_req_valid && host_req_ready && !host_req_win));
endmodule

// File: tb/cfg_addr_xlate_bench.sv
module cfg_addr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_win = 1'b0;
  logic        host_req_write = 1'b0;
  logic [11:0] host_req_offset = '0;
  logic [2:0]  host_req_len = 3'd4;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [31:0] dn_req_addr;
  logic        dn_req_write;
  logic [2:0]  dn_req_len;
  logic [31:0] dn_req_wdata;
  logic        dn_rsp_valid = 1'b0;
  logic [31:0] dn_rsp_rdata = '0;

  int checks = 0;
  int errors = 0;
  bit tb_busy = 1'b0;
  bit done = 1'b0;
  int seed = 0;
  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_wdata_q[$];
  logic [2:0]  exp_len_q[$];
  bit          exp_wr_q[$];

  always #10 clk = ~clk;

  cfg_addr_xlate u_cfg_addr_xlate (
    .clk, .rst_n, .host_req_valid, .host_req_ready, .host_req_win, .host_req_write,
    .host_req_offset, .host_req_len, .host_req_wdata, .host_rsp_valid, .host_rsp_rdata,
    .dn_req_valid, .dn_req_ready, .dn_req_addr, .dn_req_write, .dn_req_len,
    .dn_req_wdata, .dn_rsp_valid, .dn_rsp_rdata
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] idx, input logic [11:0] ofs);
    logic [31:0] dev;
    if (idx[31]) return idx | {30'd0, ofs[1:0]};
    if (idx[0])  return (idx & ~32'd7) | {29'd0, ofs[2:0]};
    dev = 32'hFFFF_FFFF;
    for (int b = 31; b >= 11; b--) if (idx[b]) dev = b - 11;
    return (dev << 11) | {21'd0, idx[10:8], 8'd0} | (idx & 32'hF8) | {29'd0, ofs[2:0]};
  endfunction

  function automatic logic [31:0] resp_of(input logic [31:0] a);
    return a ^ 32'hA5A5_0000;
  endfunction

  logic [31:0] idx_model = '0;

  task automatic host_access(input bit win, input bit wr, input logic [11:0] ofs,
                             input logic [2:0] len, input logic [31:0] wd, input string tag);
    bit rdy;
    logic [31:0] exp;
    if (win) begin
      exp = model_addr(idx_model, ofs);
      exp_addr_q.push_back(exp); exp_wdata_q.push_back(wd);
      exp_len_q.push_back(len);  exp_wr_q.push_back(wr);
    end
    host_req_valid = 1'b1; host_req_win = win; host_req_write = wr;
    host_req_offset = ofs; host_req_len = len; host_req_wdata = wd;
    forever begin
      rdy = host_req_ready;
      @(posedge clk); #1;
      if (rdy) break;
    end
    host_req_valid = 1'b0;
    if (!win) begin
      chk(host_rsp_valid, {tag, " R7 index response next cycle"}, 32'(host_rsp_valid), 32'd1);
      if (wr) begin
        idx_model = wd;
        chk(host_rsp_rdata == 32'd0, {tag, " R9 write data zero"}, host_rsp_rdata, 32'd0);
      end else begin
        chk(host_rsp_rdata == idx_model, {tag, " R7 index readback"}, host_rsp_rdata, idx_model);
      end
    end else begin
      tb_busy = 1'b1;
      while (!host_rsp_valid) begin @(posedge clk); #1; end
      tb_busy = 1'b0;
      exp = wr ? 32'd0 : resp_of(model_addr(idx_model, ofs));
      chk(host_rsp_rdata == exp, {tag, " R9 response data"}, host_rsp_rdata, exp);
    end
  endtask

  // downstream responder
  initial begin
    logic [31:0] ea, ew; logic [2:0] el; bit ewr;
    forever begin
      @(posedge clk); #1;
      if (dn_req_valid) begin
        ea = exp_addr_q.pop_front(); ew = exp_wdata_q.pop_front();
        el = exp_len_q.pop_front();  ewr = exp_wr_q.pop_front();
        chk(dn_req_addr == ea, "R1/R2/R3/R4/R5 address", dn_req_addr, ea);
        chk(dn_req_len == el && dn_req_write == ewr, "R6 len/dir", {28'd0, dn_req_write, dn_req_len}, {28'd0, ewr, el});
        if (ewr) chk(dn_req_wdata == ew, "R6 wdata", dn_req_wdata, ew);
        seed++;
        repeat (seed % 3) begin
          @(posedge clk); #1;
          chk(dn_req_valid && dn_req_addr == ea, "R8 request held", dn_req_addr, ea);
        end
        dn_req_ready = 1'b1;
        @(posedge clk); #1;
        dn_req_ready = 1'b0;
        repeat (1 + seed % 2) @(posedge clk);
        #1;
        dn_rsp_valid = 1'b1; dn_rsp_rdata = resp_of(ea);
        @(posedge clk); #1;
        dn_rsp_valid = 1'b0; dn_rsp_rdata = '0;
      end
    end
  end

  // per-cycle ready comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (host_req_ready !== !tb_busy) begin
        errors++;
        $display("FAIL R8 ready actual=%0b expected=%0b", host_req_ready, !tb_busy);
      end
      checks++;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(host_req_ready && !dn_req_valid && !host_rsp_valid, "R7 reset state", {30'd0, dn_req_valid, host_req_ready}, 32'd1);
    rst_n = 1'b1;
    @(posedge clk); #1;
    host_access(1'b0, 1'b0, 12'h000, 3'd4, 32'd0, "R7 reset index zero");
    host_access(1'b0, 1'b1, 12'h000, 3'd1, 32'h8000_1234, "R7 write");
    host_access(1'b0, 1'b0, 12'h000, 3'd4, 32'd0, "R7 read");
    host_access(1'b1, 1'b0, 12'h003, 3'd1, 32'd0, "R1 pass");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h8000_0001, "R1 setup");
    host_access(1'b1, 1'b1, 12'h006, 3'd2, 32'hDEAD_BEEF, "R1 both bits");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h0012_3459, "R2 setup");
    host_access(1'b1, 1'b0, 12'hFF6, 3'd4, 32'd0, "R2 type1");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h0000_0D2C, "R4 setup");
    host_access(1'b1, 1'b1, 12'h001, 3'd1, 32'h1122_3344, "R4 fields");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h0018_0310, "R3 setup");
    host_access(1'b1, 1'b0, 12'h007, 3'd2, 32'd0, "R3 lowest");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h4000_0000, "R3 setup top");
    host_access(1'b1, 1'b0, 12'h004, 3'd4, 32'd0, "R3 top bit");
    host_access(1'b0, 1'b1, 12'h000, 3'd4, 32'h0000_06F6, "R5 setup");
    host_access(1'b1, 1'b0, 12'h00C, 3'd4, 32'd0, "R5 empty");
    host_access(1'b1, 1'b1, 12'h002, 3'd2, 32'h0000_ABCD, "R6 write");
    host_access(1'b0, 1'b0, 12'h000, 3'd4, 32'd0, "R7 index kept");
    repeat (4) @(posedge clk);
    #1;
    chk(exp_addr_q.size() == 0, "R8 all requests seen", 32'(exp_addr_q.size()), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule